// File: doc/BRIEF.md
# Seven-Level Staircase Gate Sequencer

This block drives the gates of a single-phase seven-level inverter built from two H-bridges in series, with DC sources in a 1:2 ratio. The low-voltage bridge carries a weight of one unit and the high-voltage bridge a weight of two units. The output is a staircase. During each half cycle it climbs from zero to three units and then falls back to zero. The positive half cycle comes first and the negative half cycle follows.

A prescaler produces a step tick once every `DIV` enabled clock cycles. Each tick advances a step counter, and sixteen steps make one fundamental period. The output frequency is therefore f_clk / (16 × DIV). For example, a 1 MHz clock with DIV = 1250 gives 50 Hz.

The step counter is held as a phase state machine and a two-bit step index within the phase. The state machine has four states:
- `PH_POS_RISE`: the positive half cycle, ramping up.
- `PH_POS_FALL`: the positive half cycle, ramping down.
- `PH_NEG_RISE`: the negative half cycle, ramping up.
- `PH_NEG_FALL`: the negative half cycle, ramping down.

The state machine takes one transition when a tick arrives while the step index is all ones. That transition moves it along the ring POS_RISE → POS_FALL → NEG_RISE → NEG_FALL → POS_RISE. Any other tick only increments the step index. Without a tick, the state and the index hold.

In a falling state, the magnitude code is the bitwise complement of the step index. In a rising state, it is the step index itself. Bit b of the code switches bridge b. One leg of every bridge is held on for the whole half cycle, so only the diagonal partner switch toggles. All gate enables and a signed level code are registered.

Top module: `mli_stair_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `gate_en` and `level` reads 0 after that edge. The step counter and the prescaler restart from zero.
- R2: With `en` held high, the step counter advances exactly once every `DIV` clock edges. Each level is therefore held for `DIV` cycles.
- R3: In the rising quarter of each half cycle, the magnitude steps through 0, 1, 2, 3.
- R4: In the falling quarter of each half cycle, the magnitude mirrors the rising quarter and steps through 3, 2, 1, 0.
- R5: The first half of every period is positive and the second half is negative. The negative half repeats the magnitudes of the positive half with the sign reversed.
- R6: The `gate_en` bus uses bit 4b+0 for T1, bit 4b+1 for T2, bit 4b+2 for T3 and bit 4b+3 for T4 of bridge b. While enabled in the positive half cycle, T1 of every bridge is on and T3 is off. In the negative half cycle, T3 of every bridge is on and T1 is off.
- R7: Bridge 0 (weight 1) follows magnitude bit 0 and bridge 1 (weight 2) follows magnitude bit 1. A bridge whose bit is set has T4 on in the positive half cycle and T2 on in the negative half cycle. A bridge whose bit is clear keeps its partner switch off.
- R8: T1 and T2 of a bridge are never on together. T3 and T4 of a bridge are never on together.
- R9: An edge where `en` is low leaves all gates and `level` at 0 and freezes the step counter and the prescaler. When `en` returns high, the sequence resumes from where it stopped.
- R10: `level` is a two's-complement value equal to the magnitude (2·bit1 + bit0). It is negated in the negative half cycle.
- R11: The outputs are registered. After a clock edge they show the step counter value held before that edge, so they lag a counter step by one cycle.
- R12: After 16 steps the counter wraps, and the sequence repeats from the zero level of the positive half cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; when low, gates are forced off and the sequence is frozen |
| gate_en | output | 4*NBR | Gate enables; bits 4b+0..4b+3 are T1..T4 of bridge b |
| level | output | NBR+1 | Signed staircase level in units |

## Verification
The counter value after an edge is the number of earlier enabled edges divided by `DIV`. The outputs after an edge reflect the counter value before that edge, so each result is due exactly one edge after the state that causes it. The scoreboard builds each expected item at the rising edge, using the inputs that edge sampled and the count of enabled edges before it. The monitor compares that item with the outputs at the next falling edge. Disabled and reset edges queue an all-off item in the same way, so a step that is late or early by a single cycle is caught.

// File: rtl/mli_seq_pkg.sv
package mli_seq_pkg;

    typedef enum logic [1:0] {
        PH_POS_RISE = 2'd0,
        PH_POS_FALL = 2'd1,
        PH_NEG_RISE = 2'd2,
        PH_NEG_FALL = 2'd3
    } phase_t;

    localparam int LEG_T1 = 0;
    localparam int LEG_T2 = 1;
    localparam int LEG_T3 = 2;
    localparam int LEG_T4 = 3;
    localparam int LEGS   = 4;

    function automatic logic phase_is_neg(input phase_t ph);
        return (ph == PH_NEG_RISE) || (ph == PH_NEG_FALL);
    endfunction

    function automatic logic phase_is_fall(input phase_t ph);
        return (ph == PH_POS_FALL) || (ph == PH_NEG_FALL);
    endfunction

endpackage

// File: rtl/mli_step_tick.sv
module mli_step_tick #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_direct
            assign tick = en;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;

            assign tick = en && (pre_q == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    pre_q <= '0;
                end else if (en) begin
                    pre_q <= tick ? '0 : pre_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mli_phase_fsm.sv
module mli_phase_fsm
    import mli_seq_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output phase_t            phase,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] STEP_LAST = '1;

    phase_t phase_q, phase_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic quarter_done;

    assign quarter_done = tick && (step_q == STEP_LAST);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_POS_RISE: if (quarter_done) phase_d = PH_POS_FALL;
            PH_POS_FALL: if (quarter_done) phase_d = PH_NEG_RISE;
            PH_NEG_RISE: if (quarter_done) phase_d = PH_NEG_FALL;
            PH_NEG_FALL: if (quarter_done) phase_d = PH_POS_RISE;
            default:                       phase_d = PH_POS_RISE;
        endcase
    end

    always_comb begin
        step_d = tick ? step_q + 1'b1 : step_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_POS_RISE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else begin
            step_q <= step_d;
        end
    end

    assign phase = phase_q;
    assign step  = step_q;

endmodule

// File: rtl/mli_gate_drive.sv
module mli_gate_drive
    import mli_seq_pkg::*;
#(
    parameter int NBR = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  phase_t                  phase,
    input  logic [NBR-1:0]          step,
    output logic [LEGS*NBR-1:0]     gate_en,
    output logic signed [NBR:0]     level
);

    localparam int LW = NBR + 1;

    logic [NBR-1:0] mag;
    logic           neg;
    logic signed [LW-1:0] mag_s;

    assign neg   = phase_is_neg(phase);
    assign mag   = phase_is_fall(phase) ? ~step : step;
    assign mag_s = $signed({1'b0, mag});

    generate
        for (genvar b = 0; b < NBR; b++) begin : g_bridge
            logic [LEGS-1:0] leg_q;
            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    leg_q <= '0;
                end else begin
                    leg_q[LEG_T1] <= !neg;
                    leg_q[LEG_T2] <= neg && mag[b];
                    leg_q[LEG_T3] <= neg;
                    leg_q[LEG_T4] <= !neg && mag[b];
                end
            end
            assign gate_en[LEGS*b +: LEGS] = leg_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            level <= '0;
        end else begin
            level <= neg ? -mag_s : mag_s;
        end
    end

endmodule

// File: rtl/mli_stair_seq.sv
module mli_stair_seq
    import mli_seq_pkg::*;
#(
    parameter int DIV = 1250,
    parameter int NBR = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    output logic [4*NBR-1:0]     gate_en,
    output logic signed [NBR:0]  level
);

    logic           tick;
    phase_t         phase;
    logic [NBR-1:0] step;

    mli_step_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick)
    );

    mli_phase_fsm #(.STEP_W(NBR)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (phase),
        .step  (step)
    );

    mli_gate_drive #(.NBR(NBR)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .phase   (phase),
        .step    (step),
        .gate_en (gate_en),
        .level   (level)
    );

endmodule

// File: rtl/mli_seq_chk.sv
module mli_seq_chk #(
    parameter int NBR = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [4*NBR-1:0]    gate_en,
    input logic signed [NBR:0] level
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (gate_en == '0 && level == '0)); // R1

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate_en == '0 && level == '0)); // R9

    generate
        for (genvar b = 0; b < NBR; b++) begin : g_chk
            AST_NO_SHOOT_HI: assert property (@(posedge clk) disable iff (rst)
                !(gate_en[4*b+0] && gate_en[4*b+1])); // R8
            AST_NO_SHOOT_LO: assert property (@(posedge clk) disable iff (rst)
                !(gate_en[4*b+2] && gate_en[4*b+3])); // R8
            AST_POS_LEG: assert property (@(posedge clk) disable iff (rst)
                (level > 0) |-> (gate_en[4*b+0] && !gate_en[4*b+2])); // R6
            AST_NEG_LEG: assert property (@(posedge clk) disable iff (rst)
                (level < 0) |-> (gate_en[4*b+2] && !gate_en[4*b+0])); // R6
        end
    endgenerate

endmodule

bind mli_stair_seq mli_seq_chk #(.NBR(NBR)) u_seq_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .gate_en (gate_en),
    .level   (level)
);

// File: tb/test_mli_stair_seq.sv
module test_mli_stair_seq;

    localparam int DIV = 3;
    localparam int NBR = 2;

    typedef struct {
        logic [4*NBR-1:0] gates;
        int               lvl;
        string            req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [4*NBR-1:0]    gate_en;
    logic signed [NBR:0] level;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   k      = 0;
    bit   done   = 1'b0;

    always #2ns clk = ~clk;

    mli_stair_seq #(.DIV(DIV), .NBR(NBR)) i_mli_stair_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .gate_en (gate_en),
        .level   (level)
    );

    function automatic exp_t model(input int c);
        exp_t e;
        logic [3:0] cv = 4'(c % 16);
        logic       neg = cv[3];
        logic [1:0] mag = cv[2] ? ~cv[1:0] : cv[1:0];
        e.gates = '0;
        for (int b = 0; b < NBR; b++) begin
            e.gates[4*b+0] = !neg;
            e.gates[4*b+1] = neg && mag[b];
            e.gates[4*b+2] = neg;
            e.gates[4*b+3] = !neg && mag[b];
        end
        e.lvl = neg ? -int'(mag) : int'(mag);
        if (cv[2]) e.req = neg ? "R4 R5 R6 R7 R10 R11" : "R4 R6 R7 R10 R11";
        else       e.req = neg ? "R3 R5 R6 R7 R10 R11" : "R2 R3 R6 R7 R10 R11";
        if (c >= 16) e.req = {e.req, " R12"};
        return e;
    endfunction

    task automatic cyc(input logic r, input logic e_in);
        exp_t ex;
        rst = r;
        en  = e_in;
        @(posedge clk);
        if (r) begin
            ex.gates = '0; ex.lvl = 0; ex.req = "R1";
            k = 0;
        end else if (!e_in) begin
            ex.gates = '0; ex.lvl = 0; ex.req = "R9";
        end else begin
            ex = model(k / DIV);
            k++;
        end
        q.push_back(ex);
        @(negedge clk);
    endtask

    task automatic run(input logic r, input logic e_in, input int n);
        for (int i = 0; i < n; i++) cyc(r, e_in);
    endtask

    initial begin : monitor
        exp_t ex;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                ex = q.pop_front();
                n_chk++;
                if (gate_en !== ex.gates || int'(level) != ex.lvl) begin
                    n_fail++;
                    $display("FAIL %s: gates=%b level=%0d expected gates=%b level=%0d",
                             ex.req, gate_en, $signed(level), ex.gates, ex.lvl);
                end
                for (int b = 0; b < NBR; b++) begin
                    n_chk++;
                    if ((gate_en[4*b+0] && gate_en[4*b+1]) ||
                        (gate_en[4*b+2] && gate_en[4*b+3])) begin
                        n_fail++;
                        $display("FAIL R8: bridge %0d legs=%b expected no shorted leg pair",
                                 b, gate_en[4*b +: 4]);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        @(negedge clk);
        run(1'b1, 1'b0, 4);           // R1 reset state
        run(1'b0, 1'b1, 2 * 16 * DIV + 4); // R2 R3 R4 R5 R12 two periods
        run(1'b0, 1'b0, 5);           // R9 freeze
        run(1'b0, 1'b1, 20);          // R9 resume
        run(1'b1, 1'b1, 3);           // R1 mid-run reset
        run(1'b0, 1'b1, 30);
        run(1'b0, 1'b0, 2);
        @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d items unchecked, expected 0", q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule